// File: doc/BRIEF.md
# Asynchronous Character Receiver

This block turns a serial line into parallel characters. A bit-rate clock from outside the block, `rx_clk_i`, paces reception. It runs at 1, 16 or 64 times the bit rate. The block samples this clock and the data line into its own system clock domain, and each rising edge of the bit-rate clock becomes a one-cycle tick.

At 16x and 64x, a low level seen while idle opens a candidate start bit. The block checks that candidate at its half-bit point, and a glitch shorter than half a bit is thrown away. Each later bit is sampled one full bit period after the one before. At 1x, every rising edge of the bit-rate clock samples one bit.

The character length is 5 to 8 bits, sent LSB first. An optional parity bit follows the data, then a stop bit. The received character is held for the host with a ready flag. The block keeps sticky parity, framing and overrun flags, and raises a break indication when the line stays low across frames.

The host clears the ready flag with a one-cycle read acknowledge. It clears the three error flags with a one-cycle error-clear pulse.

Top module: `serial_char_receiver`

## Requirements
- R1: At 16x or 64x, a low line seen on an idle tick is checked again 8 or 32 ticks later. If the line is high at that point, the start is dropped and the receiver goes back to idle with nothing delivered. A low lasting more than half a bit is taken as a start bit.
- R2: Encodings:
  - `factor_i`: 00 selects 1x, 01 selects 16x, 10 or 11 selects 64x.
  - `char_len_i`: code n selects 5+n data bits.

  At 16x or 64x, each data, parity and stop bit is sampled 16 or 64 ticks after the previous sample. At 1x, one bit is sampled per tick. Data arrives LSB first, and bits above the character length read as zero.
- R3: `rx_rdy_o` rises in the cycle after the stop bit is sampled, and `rx_data_o` then holds the character. A one-cycle `rd_ack_i` clears `rx_rdy_o` on the next cycle.
- R4: If a character completes while `rx_rdy_o` is still set and no `rd_ack_i` arrives in that cycle, `ovr_err_o` sets and `rx_data_o` is replaced by the new character.
- R5: A stop bit sampled low sets `frm_err_o`.
- R6: With `par_en_i` high, a parity bit follows the last data bit. `par_even_i` = 1 selects even parity and 0 selects odd. A mismatch sets `par_err_o`, but only for a frame whose stop bit is high, so a break does not leave a parity error behind.
- R7: All three error flags change only when a character is delivered or when `err_clr_i` pulses. They stay set until `err_clr_i` clears all three. If a delivery sets a flag in the same cycle as a clear, the set wins.
- R8: `brk_det_o` sets when a stop bit is sampled low and the line has stayed low since the previous stop bit, which was also low. It clears on the cycle after the synchronized line reads high, and it is low after reset.
- R9: While `rx_en_i` is low, no character is assembled, `rx_rdy_o` is forced low from the next cycle, and the error flags are left unchanged.
- R10: After reset, `rx_rdy_o`, `rx_data_o` and all error and break flags are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_clk_i | input | 1 | Bit-rate clock from outside, 1x/16x/64x |
| rxd_i | input | 1 | Serial data line, idle high |
| rx_en_i | input | 1 | Receiver enable |
| factor_i | input | 2 | Rate factor code |
| char_len_i | input | 2 | Character length code (5+n bits) |
| par_en_i | input | 1 | Parity bit present |
| par_even_i | input | 1 | 1 = even parity, 0 = odd |
| rd_ack_i | input | 1 | One-cycle read acknowledge |
| err_clr_i | input | 1 | One-cycle error flag clear |
| rx_data_o | output | DATA_W | Last delivered character |
| rx_rdy_o | output | 1 | Character waiting |
| par_err_o | output | 1 | Sticky parity error |
| frm_err_o | output | 1 | Sticky framing error |
| ovr_err_o | output | 1 | Sticky overrun error |
| brk_det_o | output | 1 | Break detected |

## Verification
The properties assume the following about the inputs:
- The bit-rate clock is much slower than the system clock.
- The data line changes only well away from a rising edge of the bit-rate clock.
- The configuration inputs hold still while a frame is in flight.
- Acknowledge and clear are single-cycle pulses.

The stimulus gives the bit-rate clock four system cycles low and four high. It changes the line only at the start of the low phase, and it changes the configuration only between frames, after an idle bit.

// File: rtl/rx_pkg.sv
package rx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP
  } rx_state_e;

  localparam logic [1:0] FAC_X1  = 2'b00;
  localparam logic [1:0] FAC_X16 = 2'b01;
endpackage

// File: rtl/rx_sync.sv
module rx_sync #(
  parameter int         W       = 2,
  parameter int         STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] stg_q;
  logic [STAGES-1:0][W-1:0] stg_d;

  always_comb begin
    stg_d = {stg_q[STAGES-2:0], d_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg_q <= {STAGES{RST_VAL}};
    else        stg_q <= stg_d;
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/rx_edge.sv
module rx_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl_i,
  output logic rise_o
);
  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b1;
    else        prev_q <= lvl_i;
  end

  assign rise_o = lvl_i & ~prev_q;
endmodule

// File: rtl/rx_frame.sv
module rx_frame
  import rx_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int MIN_LEN = 5,
  parameter int DIV_MID = 16,
  parameter int DIV_HI  = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              rxd_i,
  input  logic              en_i,
  input  logic [1:0]        factor_i,
  input  logic [1:0]        len_i,
  input  logic              par_en_i,
  output logic              done_o,
  output logic [DATA_W-1:0] data_o,
  output logic              par_o,
  output logic              stop_o
);
  localparam int CNT_W = $clog2(DIV_HI);
  localparam int IDX_W = $clog2(DATA_W);

  rx_state_e         st_q, st_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic [DATA_W-1:0] sh_q, sh_d;
  logic              par_q, par_d;

  logic              is_x1;
  logic [CNT_W-1:0]  full_lim, half_lim;
  logic              at_full, at_half;
  logic [IDX_W-1:0]  last_idx;

  assign is_x1    = (factor_i == FAC_X1);
  assign full_lim = (factor_i == FAC_X16) ? CNT_W'(DIV_MID - 1)   : CNT_W'(DIV_HI - 1);
  assign half_lim = (factor_i == FAC_X16) ? CNT_W'(DIV_MID/2 - 1) : CNT_W'(DIV_HI/2 - 1);
  assign at_full  = is_x1 | (cnt_q == full_lim);
  assign at_half  = (cnt_q == half_lim);
  assign last_idx = IDX_W'(MIN_LEN - 1) + IDX_W'(len_i);

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    idx_d  = idx_q;
    sh_d   = sh_q;
    par_d  = par_q;
    done_o = 1'b0;
    if (!en_i) begin
      st_d  = ST_IDLE;
      cnt_d = '0;
    end else if (tick_i) begin
      unique case (st_q)
        ST_IDLE: begin
          if (!rxd_i) begin
            cnt_d = '0;
            idx_d = '0;
            sh_d  = '0;
            par_d = 1'b0;
            st_d  = is_x1 ? ST_DATA : ST_START;
          end
        end
        ST_START: begin
          if (at_half) begin
            cnt_d = '0;
            st_d  = rxd_i ? ST_IDLE : ST_DATA;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        ST_DATA: begin
          if (at_full) begin
            cnt_d       = '0;
            sh_d[idx_q] = rxd_i;
            if (idx_q == last_idx) st_d = par_en_i ? ST_PAR : ST_STOP;
            else                   idx_d = idx_q + 1'b1;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        ST_PAR: begin
          if (at_full) begin
            cnt_d = '0;
            par_d = rxd_i;
            st_d  = ST_STOP;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        ST_STOP: begin
          if (at_full) begin
            cnt_d  = '0;
            done_o = 1'b1;
            st_d   = ST_IDLE;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        default: st_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
      idx_q <= '0;
      sh_q  <= '0;
      par_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      idx_q <= idx_d;
      sh_q  <= sh_d;
      par_q <= par_d;
    end
  end

  assign data_o = sh_q;
  assign par_o  = par_q;
  assign stop_o = rxd_i;
endmodule

// File: rtl/rx_flags.sv
module rx_flags #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_i,
  input  logic              done_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              par_i,
  input  logic              stop_i,
  input  logic              par_en_i,
  input  logic              par_even_i,
  input  logic              rxd_i,
  input  logic              rd_ack_i,
  input  logic              err_clr_i,
  output logic [DATA_W-1:0] data_o,
  output logic              rdy_o,
  output logic              pe_o,
  output logic              fe_o,
  output logic              oe_o,
  output logic              brk_o
);
  logic [DATA_W-1:0] data_q, data_d;
  logic rdy_q, rdy_d, pe_q, pe_d, fe_q, fe_d, oe_q, oe_d;
  logic brk_q, brk_d, low_q, low_d;
  logic pe_new, fe_new, oe_new;

  assign pe_new = par_en_i & stop_i & (^data_i ^ par_i ^ ~par_even_i);
  assign fe_new = ~stop_i;
  assign oe_new = rdy_q & ~rd_ack_i;

  always_comb begin
    data_d = done_i ? data_i : data_q;
    if (!en_i)          rdy_d = 1'b0;
    else if (done_i)    rdy_d = 1'b1;
    else if (rd_ack_i)  rdy_d = 1'b0;
    else                rdy_d = rdy_q;
    pe_d = (pe_q & ~err_clr_i) | (done_i & pe_new);
    fe_d = (fe_q & ~err_clr_i) | (done_i & fe_new);
    oe_d = (oe_q & ~err_clr_i) | (done_i & oe_new);
    if (rxd_i) begin
      low_d = 1'b0;
      brk_d = 1'b0;
    end else begin
      low_d = low_q | (done_i & fe_new);
      brk_d = brk_q | (done_i & fe_new & low_q);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      rdy_q  <= 1'b0;
      pe_q   <= 1'b0;
      fe_q   <= 1'b0;
      oe_q   <= 1'b0;
      brk_q  <= 1'b0;
      low_q  <= 1'b0;
    end else begin
      data_q <= data_d;
      rdy_q  <= rdy_d;
      pe_q   <= pe_d;
      fe_q   <= fe_d;
      oe_q   <= oe_d;
      brk_q  <= brk_d;
      low_q  <= low_d;
    end
  end

  assign data_o = data_q;
  assign rdy_o  = rdy_q;
  assign pe_o   = pe_q;
  assign fe_o   = fe_q;
  assign oe_o   = oe_q;
  assign brk_o  = brk_q;
endmodule

// File: rtl/serial_char_receiver.sv
module serial_char_receiver #(
  parameter int DATA_W      = 8,
  parameter int MIN_LEN     = 5,
  parameter int DIV_MID     = 16,
  parameter int DIV_HI      = 64,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_clk_i,
  input  logic              rxd_i,
  input  logic              rx_en_i,
  input  logic [1:0]        factor_i,
  input  logic [1:0]        char_len_i,
  input  logic              par_en_i,
  input  logic              par_even_i,
  input  logic              rd_ack_i,
  input  logic              err_clr_i,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              rx_rdy_o,
  output logic              par_err_o,
  output logic              frm_err_o,
  output logic              ovr_err_o,
  output logic              brk_det_o
);
  logic [1:0]        rst_pipe_q;
  logic              rst_sync_n;
  logic [1:0]        sync_q;
  logic              rxc_s, rxd_s, tick;
  logic              char_done, par_bit, stop_bit;
  logic [DATA_W-1:0] asm_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[1];

  rx_sync #(.W(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b11)) u_sync (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .d_i   ({rx_clk_i, rxd_i}),
    .q_o   (sync_q)
  );
  assign rxc_s = sync_q[1];
  assign rxd_s = sync_q[0];

  rx_edge u_edge (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .lvl_i  (rxc_s),
    .rise_o (tick)
  );

  rx_frame #(.DATA_W(DATA_W), .MIN_LEN(MIN_LEN), .DIV_MID(DIV_MID), .DIV_HI(DIV_HI)) u_frame (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .tick_i   (tick),
    .rxd_i    (rxd_s),
    .en_i     (rx_en_i),
    .factor_i (factor_i),
    .len_i    (char_len_i),
    .par_en_i (par_en_i),
    .done_o   (char_done),
    .data_o   (asm_data),
    .par_o    (par_bit),
    .stop_o   (stop_bit)
  );

  rx_flags #(.DATA_W(DATA_W)) u_flags (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .en_i       (rx_en_i),
    .done_i     (char_done),
    .data_i     (asm_data),
    .par_i      (par_bit),
    .stop_i     (stop_bit),
    .par_en_i   (par_en_i),
    .par_even_i (par_even_i),
    .rxd_i      (rxd_s),
    .rd_ack_i   (rd_ack_i),
    .err_clr_i  (err_clr_i),
    .data_o     (rx_data_o),
    .rdy_o      (rx_rdy_o),
    .pe_o       (par_err_o),
    .fe_o       (frm_err_o),
    .oe_o       (ovr_err_o),
    .brk_o      (brk_det_o)
  );
endmodule

// File: rtl/rx_checker.sv
module rx_checker #(
  parameter int DATA_W  = 8,
  parameter int MIN_LEN = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rx_en_i,
  input logic              rd_ack_i,
  input logic              err_clr_i,
  input logic [1:0]        char_len_i,
  input logic              char_done,
  input logic              stop_bit,
  input logic              rxd_s,
  input logic [DATA_W-1:0] rx_data_o,
  input logic              rx_rdy_o,
  input logic              par_err_o,
  input logic              frm_err_o,
  input logic              ovr_err_o,
  input logic              brk_det_o
);
  p_upper_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    char_done |=> ((rx_data_o >> (MIN_LEN + $past(char_len_i))) == '0));

  p_rdy_on_done_r3: assert property (@(posedge clk) disable iff (!rst_n)
    char_done |=> rx_rdy_o);

  p_ack_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_ack_i && !char_done) |=> !rx_rdy_o);

  p_overrun_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (char_done && rx_rdy_o && !rd_ack_i) |=> ovr_err_o);

  p_framing_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (char_done && !stop_bit) |=> frm_err_o);

  p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (err_clr_i && !char_done) |=> (!par_err_o && !frm_err_o && !ovr_err_o));

  p_brk_with_fe_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(brk_det_o) |-> frm_err_o);

  p_brk_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rxd_s |=> !brk_det_o);

  p_disabled_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en_i |=> !rx_rdy_o);
endmodule

bind serial_char_receiver rx_checker #(.DATA_W(DATA_W), .MIN_LEN(MIN_LEN)) i_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .rx_en_i    (rx_en_i),
  .rd_ack_i   (rd_ack_i),
  .err_clr_i  (err_clr_i),
  .char_len_i (char_len_i),
  .char_done  (char_done),
  .stop_bit   (stop_bit),
  .rxd_s      (rxd_s),
  .rx_data_o  (rx_data_o),
  .rx_rdy_o   (rx_rdy_o),
  .par_err_o  (par_err_o),
  .frm_err_o  (frm_err_o),
  .ovr_err_o  (ovr_err_o),
  .brk_det_o  (brk_det_o)
);

// File: tb/test_serial_char_receiver.sv
module test_serial_char_receiver;
  logic       clk = 1'b0;
  logic       rst_n, rxc, rxd, rx_en, pen, peven, rd_ack, err_clr;
  logic [1:0] fac, len;
  logic [7:0] rx_data;
  logic       rx_rdy, pe, fe, oe, brk;

  int   n_tests = 0;
  int   n_fail  = 0;
  logic       exp_rdy, exp_pe, exp_fe, exp_oe;
  logic [7:0] exp_data;

  always #5 clk = ~clk;

  serial_char_receiver i_serial_char_receiver (
    .clk(clk), .rst_n(rst_n), .rx_clk_i(rxc), .rxd_i(rxd), .rx_en_i(rx_en),
    .factor_i(fac), .char_len_i(len), .par_en_i(pen), .par_even_i(peven),
    .rd_ack_i(rd_ack), .err_clr_i(err_clr), .rx_data_o(rx_data), .rx_rdy_o(rx_rdy),
    .par_err_o(pe), .frm_err_o(fe), .ovr_err_o(oe), .brk_det_o(brk)
  );

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", what, act, exp);
    end
  endtask

  function automatic int div_of(input logic [1:0] f);
    if (f == 2'b00) return 1;
    if (f == 2'b01) return 16;
    return 64;
  endfunction

  function automatic logic [7:0] mask_of(input logic [1:0] l);
    return 8'((9'd1 << (5 + l)) - 9'd1);
  endfunction

  task automatic rx_cycle();
    rxc = 1'b0;
    repeat (4) @(negedge clk);
    rxc = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic send_bit(input logic b, input int n);
    rxd = b;
    for (int k = 0; k < n; k++) rx_cycle();
  endtask

  task automatic send_frame(input logic [7:0] d, input logic bad_par, input logic bad_stop);
    int n = div_of(fac);
    logic p;
    logic [7:0] dm = d & mask_of(len);
    send_bit(1'b0, n);
    for (int i = 0; i < 5 + int'(len); i++) send_bit(d[i], n);
    if (pen) begin
      p = (^dm) ^ ~peven;
      send_bit(p ^ bad_par, n);
    end
    send_bit(~bad_stop, n);
    send_bit(1'b1, n);
  endtask

  task automatic frame_model(input logic [7:0] d, input logic bp, input logic bs);
    send_frame(d, bp, bs);
    if (rx_en) begin
      exp_oe   = exp_oe | exp_rdy;
      exp_rdy  = 1'b1;
      exp_data = d & mask_of(len);
      exp_fe   = exp_fe | bs;
      exp_pe   = exp_pe | (pen & ~bs & bp);
    end
  endtask

  task automatic check_state(input string tag);
    chk({tag, " R3 ready"},   32'(rx_rdy), 32'(exp_rdy));
    chk({tag, " R2 data"},    32'(rx_data), 32'(exp_data));
    chk({tag, " R6 parity"},  32'(pe), 32'(exp_pe));
    chk({tag, " R5 framing"}, 32'(fe), 32'(exp_fe));
    chk({tag, " R4 overrun"}, 32'(oe), 32'(exp_oe));
  endtask

  task automatic do_read();
    @(negedge clk) rd_ack = 1'b1;
    @(negedge clk) rd_ack = 1'b0;
    exp_rdy = 1'b0;
  endtask

  task automatic do_clear();
    @(negedge clk) err_clr = 1'b1;
    @(negedge clk) err_clr = 1'b0;
    exp_pe = 1'b0; exp_fe = 1'b0; exp_oe = 1'b0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog expired: actual running expected done");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int unsigned seed_v;
    seed_v  = $urandom(32'd2024);
    rst_n   = 1'b0; rxc = 1'b0; rxd = 1'b1; rx_en = 1'b1;
    fac = 2'b01; len = 2'b11; pen = 1'b0; peven = 1'b1;
    rd_ack = 1'b0; err_clr = 1'b0;
    exp_rdy = 0; exp_pe = 0; exp_fe = 0; exp_oe = 0; exp_data = 0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    // R10 reset state
    check_state("R10 reset");
    chk("R10 R8 break after reset", 32'(brk), 0);
    send_bit(1'b1, 4);

    // R2: 1x mode, 8 bits
    fac = 2'b00; len = 2'b11;
    frame_model(8'hA5, 0, 0);
    check_state("R2 x1");
    do_read();
    chk("R3 ack clears", 32'(rx_rdy), 0);

    // R2/R6: 64x mode, 6 bits, even parity, upper bits zero
    fac = 2'b10; len = 2'b01; pen = 1'b1; peven = 1'b1;
    frame_model(8'hEB, 0, 0);
    check_state("R2 x64");
    do_read();

    // R6 odd parity error at 16x
    fac = 2'b01; len = 2'b10; peven = 1'b0;
    frame_model(8'h55, 1, 0);
    check_state("R6 odd bad");
    do_read();
    // R7 sticky across a clean frame
    frame_model(8'h12, 0, 0);
    check_state("R7 sticky");
    do_read();
    do_clear();
    check_state("R7 cleared");

    // R6: parity mismatch suppressed when stop low
    frame_model(8'h0F, 1, 1);
    check_state("R6 R5 bad stop");
    do_read();
    do_clear();

    // R4 overrun
    pen = 1'b0; len = 2'b11;
    frame_model(8'h3A, 0, 0);
    frame_model(8'hC4, 0, 0);
    check_state("R4 overrun");
    do_read();
    do_clear();

    // R1 short start ignored
    send_bit(1'b0, 4);
    send_bit(1'b1, 40);
    chk("R1 short start no char", 32'(rx_rdy), 0);
    frame_model(8'h3C, 0, 0);
    check_state("R1 after glitch");
    do_read();
    // R1 low longer than half a bit is a start
    send_bit(1'b0, 10);
    send_bit(1'b1, 16 * 12);
    exp_rdy = 1'b1; exp_data = 8'hFF;
    check_state("R1 long low");
    do_read();

    // R8 break with odd parity
    len = 2'b11; pen = 1'b1; peven = 1'b0;
    rxd = 1'b0;
    for (int k = 0; k < 25 * 16; k++) rx_cycle();
    chk("R8 break set", 32'(brk), 1);
    chk("R5 break framing", 32'(fe), 1);
    chk("R6 no parity from break", 32'(pe), 0);
    chk("R3 break char ready", 32'(rx_rdy), 1);
    chk("R2 break data", 32'(rx_data), 0);
    rxd = 1'b1;
    repeat (8) @(negedge clk);
    chk("R8 break clears", 32'(brk), 0);
    send_bit(1'b1, 16 * 30);
    do_read();
    do_clear();
    frame_model(8'h5C, 0, 0);
    check_state("R6 clean after break");
    chk("R8 stays low", 32'(brk), 0);

    // R9 disabled
    rx_en = 1'b0;
    repeat (3) @(negedge clk);
    exp_rdy = 1'b0;
    chk("R9 ready dropped", 32'(rx_rdy), 0);
    frame_model(8'h77, 0, 1);
    check_state("R9 disabled");
    rx_en = 1'b1;
    send_bit(1'b1, 4);

    // random mix
    for (int it = 0; it < 30; it++) begin
      logic [7:0] d;
      logic bp, bs;
      int r = int'($urandom_range(0, 7));
      fac   = (r == 0) ? 2'b10 : ((r < 3) ? 2'b00 : 2'b01);
      len   = 2'($urandom_range(0, 3));
      pen   = 1'($urandom_range(0, 1));
      peven = 1'($urandom_range(0, 1));
      d     = 8'($urandom);
      bp    = pen & ($urandom_range(0, 4) == 0);
      bs    = ($urandom_range(0, 6) == 0);
      if ($urandom_range(0, 1) == 1) do_read();
      if ($urandom_range(0, 3) == 0) do_clear();
      frame_model(d, bp, bs);
      check_state("R2 R6 random");
    end

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule